// File: doc/BRIEF.md
# Active Shield Tamper Monitor

This block guards one or more protected regions of a chip, each covered by its own mesh trace in the upper metal. For every trace it drives a pseudorandom bit stream into one end and samples what arrives at the other end. A second generator, built the same way and seeded the same way, runs beside the first. Its output is delayed by a per-channel latency setting so that it lines up with the trace's round trip. The received bit and the expected bit are then compared on every clock. If a trace is cut, bridged to a neighbour or loaded by a probe, the two streams disagree. The block filters out isolated glitches and then latches a tamper event that stays set.

Once a tamper event is latched, a response sequencer takes over. It first drives a disable mask, with one bit for each region whose shield has failed. It then issues a one-clock request to an external erase engine and waits for that engine's done signal. Last, it requests a system reset for a fixed number of clocks. The tamper flag, the failing channel index and the disable mask are kept across the requested reset and clear only on power-on reset.

Each shield bit is a continuous stream with one bit per clock and nothing to stall, so the trace pins carry no valid/ready handshake. Back-pressure does not apply: the transmitter never waits, and the receiver samples every clock. All control and status pins are plain levels, apart from the one-clock erase request.

Top module: `shield_monitor`

## Requirements
- R1: Each channel's transmit bit is bit 15 of a 16-bit shift register. On every clock this register advances to {s[14:0], s[15]^s[14]^s[12]^s[3]}. While any reset is held, the register is loaded with the channel's seed, and a zero seed is replaced by 16'hACE1.
- R2: The expected bit is the local copy of the stream, delayed by the channel's latency setting of 0 to 7 clocks. A return line that equals the transmit bit delayed by exactly that many clocks never raises tamper.
- R3: For the first 32 clocks after both resets are released, no comparison is made, and tamper cannot rise in that span.
- R4: A channel trips when a mismatch is sampled and at least one other mismatch on the same channel was sampled in the previous 7 compare clocks. Mismatches 8 or more clocks apart, or a single isolated mismatch, do not trip. tamper_o is high right after the clock that samples the tripping mismatch.
- R5: A return line held at 0 or at 1 raises tamper within the first 16 compare clocks.
- R6: fail_idx_o gives the channel that tripped first, and the lowest index wins a tie. Once the sequencer has started, bit c of region_dis_o is set for every channel c that has tripped.
- R7: tamper_o, fail_idx_o and region_dis_o clear only on por_n low. A low pulse on sys_rst_n leaves them unchanged.
- R8: One clock after tamper_o rises, region_dis_o becomes nonzero. One clock later erase_req_o is high for exactly one clock. The sequencer then waits for erase_done_i for as long as it takes, with sys_rst_req_o held low.
- R9: After erase_done_i is sampled high, sys_rst_req_o is high for exactly 16 clocks and then stays low, while region_dis_o stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, clears everything |
| sys_rst_n | input | 1 | System reset, active low; restarts generators and compare, keeps tamper state |
| seed_i | input | NCH*16 | Per-channel generator seeds, channel c at bits [16c+15:16c] |
| lat_i | input | NCH*3 | Per-channel round-trip latency in clocks, channel c at bits [3c+2:3c] |
| shield_tx_o | output | NCH | Stream driven into each shield trace |
| shield_rx_i | input | NCH | Stream returned from the far end of each trace |
| erase_done_i | input | 1 | Erase engine has finished |
| region_dis_o | output | NCH | Disable mask for protected regions |
| erase_req_o | output | 1 | One-clock memory erase request |
| sys_rst_req_o | output | 1 | System reset request |
| tamper_o | output | 1 | Sticky tamper flag |
| fail_idx_o | output | 2 | Index of the first failing channel |

## Verification
The bound checker watches, on every cycle, that tamper cannot rise during the startup window and that the flag and failing index hold once set. It also checks that the erase request lasts one clock and only comes with a nonzero disable mask, and that the reset request never runs longer than 16 clocks and only occurs while tamper is set. Several behaviours can only be shown by the bench's scenarios: the exact generator sequence, the silence of a correctly delayed loopback, the 7-against-8 clock glitch boundary, stuck-line detection, tie-breaking between channels, and the survival of the tamper state across a requested reset. Each of these needs a driven trace model and a known stimulus.

// File: rtl/shield_pkg.sv
package shield_pkg;
  typedef enum logic [2:0] {
    RS_IDLE,
    RS_MASK,
    RS_ERASE,
    RS_WAIT,
    RS_RESET,
    RS_HOLD
  } resp_state_e;
endpackage

// File: rtl/shield_lfsr.sv
module shield_lfsr #(
  parameter int          W        = 16,
  parameter int unsigned TAPS     = 32'h0000_D008,
  parameter int unsigned FALLBACK = 32'h0000_ACE1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] seed,
  output logic         bit_o
);
  localparam logic [W-1:0] TAP_V  = W'(TAPS);
  localparam logic [W-1:0] FILL_V = W'(FALLBACK);

  logic [W-1:0] st;
  logic         fb;

  assign fb    = ^(st & TAP_V);
  assign bit_o = st[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= (seed == '0) ? FILL_V : seed;
    else        st <= {st[W-2:0], fb};
  end
endmodule

// File: rtl/shield_channel.sv
module shield_channel #(
  parameter int          W        = 16,
  parameter int unsigned TAPS     = 32'h0000_D008,
  parameter int unsigned FALLBACK = 32'h0000_ACE1,
  parameter int          DLY_W    = 3,
  parameter int          WIN      = 8,
  parameter int          HITS     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_en,
  input  logic [W-1:0]     seed,
  input  logic [DLY_W-1:0] lat,
  input  logic             rx,
  output logic             tx,
  output logic             trip
);
  localparam int DEPTH = (1 << DLY_W) - 1;
  localparam int CW    = $clog2(WIN + 1);

  logic             ref_bit;
  logic [DEPTH-1:0] dl;
  logic [DEPTH:0]   taps;
  logic             exp_bit;
  logic             mis;
  logic [WIN-2:0]   win;
  logic [CW-1:0]    prior;

  shield_lfsr #(.W(W), .TAPS(TAPS), .FALLBACK(FALLBACK)) u_tx_gen (
    .clk(clk), .rst_n(rst_n), .seed(seed), .bit_o(tx)
  );

  shield_lfsr #(.W(W), .TAPS(TAPS), .FALLBACK(FALLBACK)) u_ref_gen (
    .clk(clk), .rst_n(rst_n), .seed(seed), .bit_o(ref_bit)
  );

  // tap 0 is the undelayed reference, tap k is k clocks old
  assign taps    = {dl, ref_bit};
  assign exp_bit = taps[lat];
  assign mis     = cmp_en & (rx ^ exp_bit);

  always_comb begin
    prior = '0;
    for (int i = 0; i < WIN - 1; i++) prior = prior + CW'(win[i]);
  end

  assign trip = mis && (prior >= CW'(HITS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dl  <= '0;
      win <= '0;
    end else begin
      dl  <= {dl[DEPTH-2:0], ref_bit};
      win <= {win[WIN-3:0], mis};
    end
  end
endmodule

// File: rtl/shield_resp_seq.sv
module shield_resp_seq
  import shield_pkg::*;
#(
  parameter int NCH     = 4,
  parameter int RST_LEN = 16
) (
  input  logic           clk,
  input  logic           por_n,
  input  logic           tamper,
  input  logic [NCH-1:0] fail_vec,
  input  logic           erase_done,
  output logic [NCH-1:0] region_dis,
  output logic           erase_req,
  output logic           sys_rst_req
);
  localparam int RCW = $clog2(RST_LEN + 1);

  resp_state_e   st;
  logic [RCW-1:0] rcnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st   <= RS_IDLE;
      rcnt <= '0;
    end else begin
      case (st)
        RS_IDLE:  if (tamper) st <= RS_MASK;
        RS_MASK:  st <= RS_ERASE;
        RS_ERASE: st <= RS_WAIT;
        RS_WAIT:  if (erase_done) begin
                    st   <= RS_RESET;
                    rcnt <= '0;
                  end
        RS_RESET: begin
                    rcnt <= rcnt + 1'b1;
                    if (rcnt == RCW'(RST_LEN - 1)) st <= RS_HOLD;
                  end
        default:  st <= RS_HOLD;
      endcase
    end
  end

  assign region_dis  = (st != RS_IDLE) ? fail_vec : '0;
  assign erase_req   = (st == RS_ERASE);
  assign sys_rst_req = (st == RS_RESET);
endmodule

// File: rtl/shield_monitor.sv
module shield_monitor #(
  parameter int          NCH      = 4,
  parameter int          SEED_W   = 16,
  parameter int unsigned TAPS     = 32'h0000_D008,
  parameter int unsigned FALLBACK = 32'h0000_ACE1,
  parameter int          DLY_W    = 3,
  parameter int          STARTUP  = 32,
  parameter int          WIN      = 8,
  parameter int          HITS     = 2,
  parameter int          RST_LEN  = 16,
  localparam int         IDX_W    = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                  clk,
  input  logic                  por_n,
  input  logic                  sys_rst_n,
  input  logic [NCH*SEED_W-1:0] seed_i,
  input  logic [NCH*DLY_W-1:0]  lat_i,
  output logic [NCH-1:0]        shield_tx_o,
  input  logic [NCH-1:0]        shield_rx_i,
  input  logic                  erase_done_i,
  output logic [NCH-1:0]        region_dis_o,
  output logic                  erase_req_o,
  output logic                  sys_rst_req_o,
  output logic                  tamper_o,
  output logic [IDX_W-1:0]      fail_idx_o
);
  localparam int SCW = $clog2(STARTUP + 1);

  logic           run_n;
  logic [SCW-1:0] scnt;
  logic           cmp_en;
  logic [NCH-1:0] trip;
  logic [NCH-1:0] fail_vec;
  logic           tamper_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] first_idx;

  assign run_n = por_n & sys_rst_n;

  // startup window: compare only once the delay lines are full
  always_ff @(posedge clk or negedge run_n) begin
    if (!run_n)                      scnt <= '0;
    else if (scnt != SCW'(STARTUP))  scnt <= scnt + 1'b1;
  end
  assign cmp_en = (scnt == SCW'(STARTUP));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    shield_channel #(
      .W(SEED_W), .TAPS(TAPS), .FALLBACK(FALLBACK),
      .DLY_W(DLY_W), .WIN(WIN), .HITS(HITS)
    ) u_ch (
      .clk   (clk),
      .rst_n (run_n),
      .cmp_en(cmp_en),
      .seed  (seed_i[c*SEED_W +: SEED_W]),
      .lat   (lat_i[c*DLY_W +: DLY_W]),
      .rx    (shield_rx_i[c]),
      .tx    (shield_tx_o[c]),
      .trip  (trip[c])
    );
  end

  // lowest index wins a tie
  always_comb begin
    first_idx = '0;
    for (int c = NCH - 1; c >= 0; c--) begin
      if (trip[c]) first_idx = IDX_W'(c);
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      tamper_q <= 1'b0;
      idx_q    <= '0;
      fail_vec <= '0;
    end else begin
      fail_vec <= fail_vec | trip;
      if (!tamper_q && (|trip)) begin
        tamper_q <= 1'b1;
        idx_q    <= first_idx;
      end
    end
  end

  shield_resp_seq #(.NCH(NCH), .RST_LEN(RST_LEN)) u_seq (
    .clk        (clk),
    .por_n      (por_n),
    .tamper     (tamper_q),
    .fail_vec   (fail_vec),
    .erase_done (erase_done_i),
    .region_dis (region_dis_o),
    .erase_req  (erase_req_o),
    .sys_rst_req(sys_rst_req_o)
  );

  assign tamper_o   = tamper_q;
  assign fail_idx_o = idx_q;
endmodule

// File: rtl/shield_monitor_chk.sv
module shield_monitor_chk #(
  parameter int NCH     = 4,
  parameter int IDX_W   = 2,
  parameter int STARTUP = 32,
  parameter int RST_LEN = 16
) (
  input logic             clk,
  input logic             por_n,
  input logic             sys_rst_n,
  input logic             tamper_o,
  input logic [IDX_W-1:0] fail_idx_o,
  input logic [NCH-1:0]   region_dis_o,
  input logic             erase_req_o,
  input logic             sys_rst_req_o
);
  logic run_n;
  int   since_rst;
  int   rst_run;

  assign run_n = por_n & sys_rst_n;

  always_ff @(posedge clk or negedge run_n) begin
    if (!run_n)                   since_rst <= 0;
    else if (since_rst < STARTUP) since_rst <= since_rst + 1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)             rst_run <= 0;
    else if (sys_rst_req_o) rst_run <= rst_run + 1;
    else                    rst_run <= 0;
  end

  // R3
  startup_quiet_chk: assert property (@(posedge clk) disable iff (!run_n)
    (since_rst < STARTUP) |=> !$rose(tamper_o));

  // R7
  tamper_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    tamper_o |=> tamper_o);

  // R7
  idx_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    tamper_o |=> $stable(fail_idx_o));

  // R8
  erase_pulse_chk: assert property (@(posedge clk) disable iff (!por_n)
    erase_req_o |=> !erase_req_o);

  // R8
  mask_first_chk: assert property (@(posedge clk) disable iff (!por_n)
    erase_req_o |-> (region_dis_o != '0) && tamper_o);

  // R9
  rst_len_chk: assert property (@(posedge clk) disable iff (!por_n)
    !(sys_rst_req_o && (rst_run >= RST_LEN)));

  // R9
  rst_cause_chk: assert property (@(posedge clk) disable iff (!por_n)
    sys_rst_req_o |-> tamper_o && (region_dis_o != '0) && !erase_req_o);
endmodule

bind shield_monitor shield_monitor_chk #(
  .NCH(NCH), .IDX_W(IDX_W), .STARTUP(STARTUP), .RST_LEN(RST_LEN)
) u_chk (
  .clk          (clk),
  .por_n        (por_n),
  .sys_rst_n    (sys_rst_n),
  .tamper_o     (tamper_o),
  .fail_idx_o   (fail_idx_o),
  .region_dis_o (region_dis_o),
  .erase_req_o  (erase_req_o),
  .sys_rst_req_o(sys_rst_req_o)
);

// File: tb/test_shield_monitor.sv
`timescale 1ns/1ps
module test_shield_monitor;
  localparam int NCH = 4;

  logic            clk = 1'b0;
  logic            por_n = 1'b0;
  logic            sys_rst_n = 1'b1;
  logic [NCH*16-1:0] seed_i = '0;
  logic [NCH*3-1:0]  lat_i = '0;
  logic [NCH-1:0]  tx, rx, region_dis;
  logic            erase_done = 1'b0;
  logic            erase_req, sys_rst_req, tamper;
  logic [1:0]      fail_idx;

  logic [2:0]      trace_d [NCH];
  logic [NCH-1:0]  flip = '0, stuck_en = '0, stuck_val = '0;
  logic [7:0]      thist [NCH];

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  shield_monitor i_shield_monitor (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
    .seed_i(seed_i), .lat_i(lat_i),
    .shield_tx_o(tx), .shield_rx_i(rx),
    .erase_done_i(erase_done), .region_dis_o(region_dis),
    .erase_req_o(erase_req), .sys_rst_req_o(sys_rst_req),
    .tamper_o(tamper), .fail_idx_o(fail_idx)
  );

  // trace model: pure delay plus fault injection
  always_ff @(posedge clk) begin
    for (int c = 0; c < NCH; c++) thist[c] <= {thist[c][6:0], tx[c]};
  end
  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      logic [8:0] tp;
      tp = {thist[c], tx[c]};
      rx[c] = stuck_en[c] ? stuck_val[c] : (tp[trace_d[c]] ^ flip[c]);
    end
  end

  function automatic logic [15:0] nxt(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[14] ^ s[12] ^ s[3]};
  endfunction

  function automatic bit trips(input int gap);
    return (gap >= 1) && (gap <= 7);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic power_up();
    @(negedge clk);
    por_n = 1'b0; flip = '0; stuck_en = '0; erase_done = 1'b0; sys_rst_n = 1'b1;
    cyc(3);
    por_n = 1'b1;
  endtask

  task automatic set_cfg(input logic [15:0] s [NCH], input logic [2:0] d [NCH]);
    for (int c = 0; c < NCH; c++) begin
      seed_i[c*16 +: 16] = s[c];
      lat_i[c*3 +: 3]    = d[c];
      trace_d[c]         = d[c];
    end
  endtask

  // one-clock flip on channel mask m, sampled at exactly one edge
  task automatic glitch(input logic [NCH-1:0] m);
    flip = m; cyc(1); flip = '0;
  endtask

  logic [15:0] sd [NCH];
  logic [2:0]  dd [NCH];

  initial begin
    void'($urandom(32'd1234));
    for (int c = 0; c < NCH; c++) begin sd[c] = 16'h1357 + 16'(c * 16'h2111); dd[c] = 3'(c + 1); end
    sd[3] = 16'h0000;
    set_cfg(sd, dd);
    por_n = 1'b0;
    cyc(2);
    chk(tamper == 0 && region_dis == 0 && !erase_req && !sys_rst_req, "R7 reset state", tamper, 0);
    por_n = 1'b1;

    // R1: transmit sequence from seed, zero seed replaced
    begin
      logic [15:0] m [NCH];
      int bad [NCH];
      for (int c = 0; c < NCH; c++) begin m[c] = (sd[c] == 0) ? 16'hACE1 : sd[c]; bad[c] = 0; end
      for (int k = 0; k < 40; k++) begin
        for (int c = 0; c < NCH; c++) if (tx[c] !== m[c][15]) bad[c]++;
        for (int c = 0; c < NCH; c++) m[c] = nxt(m[c]);
        cyc(1);
      end
      for (int c = 0; c < NCH; c++) chk(bad[c] == 0, "R1 generator sequence", bad[c], 0);
    end

    // R2: random seeds and latencies, exact loopback stays clean
    for (int t = 0; t < 4; t++) begin
      for (int c = 0; c < NCH; c++) begin
        sd[c] = ($urandom % 5 == 0) ? 16'h0 : 16'($urandom);
        dd[c] = 3'($urandom % 8);
      end
      set_cfg(sd, dd);
      power_up();
      cyc(250);
      chk(tamper == 0, "R2 matched latency loopback", tamper, 0);
    end

    // R2: latency one clock off trips
    power_up();
    trace_d[2] = lat_i[2*3 +: 3] + 3'd1;
    cyc(60);
    chk(tamper == 1, "R2 wrong latency detected", tamper, 1);
    trace_d[2] = lat_i[2*3 +: 3];

    // R3 + R5: stuck line
    for (int v = 0; v < 2; v++) begin
      power_up();
      stuck_en[1] = 1'b1; stuck_val[1] = 1'(v);
      cyc(32);
      chk(tamper == 0, "R3 no compare in startup", tamper, 0);
      cyc(16);
      chk(tamper == 1, "R5 stuck line within 16", tamper, 1);
      chk(fail_idx == 1, "R6 failing index", fail_idx, 1);
    end

    // R4: glitch spacing, randomized gaps plus directed 7/8 boundary
    for (int t = 0; t < 8; t++) begin
      int gap, ch;
      gap = (t == 0) ? 7 : (t == 1) ? 8 : (t == 2) ? 0 : 1 + int'($urandom % 12);
      ch  = int'($urandom % NCH);
      power_up();
      cyc(40);
      glitch(NCH'(1) << ch);
      if (gap > 0) begin
        cyc(gap - 1);
        glitch(NCH'(1) << ch);
      end
      cyc(2);
      chk(tamper == (gap > 0 && trips(gap)), "R4 glitch filter", tamper, int'(gap > 0 && trips(gap)));
      if (tamper) begin
        chk(fail_idx == 2'(ch), "R6 index of glitched channel", fail_idx, ch);
        chk(region_dis == (NCH'(1) << ch), "R6 region mask bit", region_dis, 1 << ch);
      end
    end

    // R6 tie + R8 + R9 + R7
    power_up();
    cyc(40);
    glitch(4'b1010); cyc(2); glitch(4'b1010);
    chk(tamper == 1 && fail_idx == 1, "R6 tie to lowest index", fail_idx, 1);
    chk(region_dis == 0 && !erase_req, "R8 mask not before one clock", region_dis, 0);
    cyc(1);
    chk(region_dis == 4'b1010 && !erase_req, "R8 mask first", region_dis, 10);
    cyc(1);
    chk(erase_req == 1, "R8 erase request", erase_req, 1);
    cyc(1);
    chk(erase_req == 0, "R8 erase one clock", erase_req, 0);
    begin
      int hi = 0;
      for (int k = 0; k < 20; k++) begin if (sys_rst_req || erase_req) hi++; cyc(1); end
      chk(hi == 0, "R8 waits for erase done", hi, 0);
      erase_done = 1'b1; cyc(1); erase_done = 1'b0;
      hi = 0;
      for (int k = 0; k < 24; k++) begin if (sys_rst_req) hi++; cyc(1); end
      chk(hi == 16, "R9 reset request length", hi, 16);
      chk(region_dis == 4'b1010, "R9 mask held", region_dis, 10);
    end
    sys_rst_n = 1'b0; cyc(3); sys_rst_n = 1'b1; cyc(5);
    chk(tamper == 1 && fail_idx == 1 && region_dis == 4'b1010 && !sys_rst_req,
        "R7 survives system reset", tamper, 1);
    por_n = 1'b0; cyc(2);
    chk(tamper == 0 && region_dis == 0 && fail_idx == 0, "R7 cleared by power-on", tamper, 0);
    por_n = 1'b1; cyc(2);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule